// File: doc/BRIEF.md
# Instruction-Selected Multiply-Add Datapath

This block is a three-stage pipelined arithmetic unit that carries out one entry of a small instruction table on every clock. The table is fixed at elaboration. Each entry chooses a pre-adder mode ahead of a signed multiplier, and it either uses the product or bypasses it with a two-operand X/Y sum. The entry also picks the Z operand and one of three add/subtract forms that write a 48-bit result register. That result register can feed back as an operand, so the same hardware can act as an accumulator, a multiply-accumulate, a symmetric-tap filter step or a plain adder. The choice is made per cycle by an unsigned select input.

The select input and the carry-in travel through their own register stages. Each instruction therefore meets its own data at every stage. Every register path has its own clock enable and its own synchronous clear. A table that mixes the concatenated operand with the multiplier is rejected at elaboration.

Top module: `mac_instr_dp`

## Requirements
- R1: While rst_ni is low, every register is cleared, and p_o reads 0.
- R2: The operands and select sampled at one rising edge produce their result on p_o after the third rising edge. Before that edge, p_o still shows the older value.
- R3: Pre-adder modes are A, A+D, D-A, D and -A. All operands are two's complement. When the product is used, its signed value is (pre-adder) x B, sign-extended to 48 bits.
- R4: An entry with the unit factor passes the pre-adder result, sign-extended, in place of the product.
- R5: The Z operand is 0, C, P, or P shifted arithmetically right by 17. The P forms use the value P holds when the instruction reaches the last stage.
- R6: The final forms are XY+Z+cin, Z-(XY+cin) and XY-Z, each taken modulo 2^48. XY is the product when the multiplier is used, and X+Y otherwise. The carry term is cin_i when the entry enables it, and 0 when it does not.
- R7: X is 0, P, or the concatenation {A,B} sign-extended from bit 35. Y is 0 or C. A table whose entries use both the multiplier and the concatenated operand fails elaboration.
- R8: A select value at or above the table size yields a result of 0.
- R9: clr_i bit k clears the registers of path k at the next edge. This takes priority over ce_i bit k. Path indices are: 0 D, 1 A, 2 B, 3 C, 4 product/concat, 5 P, 6 select and carry.
- R10: A low ce_i bit freezes only the registers of its own path. A result computed during the freeze uses the held operand of that path together with the fresh operands of the other paths.
- R11: With ce_i[5] low and clr_i[5] low, p_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 7 | Per-path clock enables, active high |
| clr_i | input | 7 | Per-path synchronous clears, active high |
| sel_i | input | SEL_W | Unsigned instruction select |
| a_i | input | A_W | Signed A operand |
| b_i | input | B_W | Signed B operand |
| d_i | input | D_W | Signed D operand |
| c_i | input | 48 | Signed C operand |
| cin_i | input | 1 | Carry-in |
| p_o | output | 48 | Result register P |

## Verification
The bench sweeps every select value of a seven-entry multiply table against every combination of A, B and D drawn from the extreme, unit and zero values. A second instance, built with a concatenation table, runs in parallel. Extreme operands separate sign-extension and wrap errors from ordinary arithmetic. The issue order interleaves feedback entries with non-feedback entries, so a result taken from the wrong cycle's P shows up as a mismatch. Short directed sequences check the exact latency edge, a single-path enable drop, a P hold, and a clear issued while the enable is low.

// File: rtl/mac_instr_pkg.sv
package mac_instr_pkg;
  localparam int P_W   = 48;
  localparam int NPATH = 7;
  localparam int PATH_D = 0, PATH_A = 1, PATH_B = 2, PATH_C = 3;
  localparam int PATH_M = 4, PATH_P = 5, PATH_SEL = 6;
  localparam int SHIFT_AMT = 17;

  typedef enum logic [2:0] {PRE_A = 3'd0, PRE_ADD = 3'd1, PRE_DSUB = 3'd2,
                            PRE_D = 3'd3, PRE_NEGA = 3'd4} pre_e;
  typedef enum logic [1:0] {X_ZERO = 2'd0, X_CAT = 2'd1, X_P = 2'd2} xsel_e;
  typedef enum logic [1:0] {Z_ZERO = 2'd0, Z_C = 2'd1, Z_P = 2'd2, Z_PSH = 2'd3} zsel_e;
  typedef enum logic [1:0] {F_ADD = 2'd0, F_ZSUB = 2'd1, F_NEGZ = 2'd2} form_e;

  typedef struct packed {
    pre_e  pre;
    logic  b_one;
    logic  use_mult;
    xsel_e x;
    logic  y_c;
    zsel_e z;
    logic  cin_en;
    form_e form;
  } instr_t;

  function automatic instr_t mk(pre_e pre, logic b_one, logic use_mult, xsel_e x,
                                logic y_c, zsel_e z, logic cin_en, form_e form);
    instr_t r;
    r.pre = pre; r.b_one = b_one; r.use_mult = use_mult; r.x = x;
    r.y_c = y_c; r.z = z; r.cin_en = cin_en; r.form = form;
    return r;
  endfunction

  // 0 A*B, 1 (A+D)*B+P, 2 (D-A)*B+C+cin, 3 C-(A*B+cin), 4 D*B-P, 5 -A+(P>>>17), 6 A+D
  localparam instr_t [6:0] DEF_TABLE = {
    mk(PRE_ADD,  1'b1, 1'b1, X_ZERO, 1'b0, Z_ZERO, 1'b0, F_ADD),
    mk(PRE_NEGA, 1'b1, 1'b1, X_ZERO, 1'b0, Z_PSH,  1'b0, F_ADD),
    mk(PRE_D,    1'b0, 1'b1, X_ZERO, 1'b0, Z_P,    1'b0, F_NEGZ),
    mk(PRE_A,    1'b0, 1'b1, X_ZERO, 1'b0, Z_C,    1'b1, F_ZSUB),
    mk(PRE_DSUB, 1'b0, 1'b1, X_ZERO, 1'b0, Z_C,    1'b1, F_ADD),
    mk(PRE_ADD,  1'b0, 1'b1, X_ZERO, 1'b0, Z_P,    1'b0, F_ADD),
    mk(PRE_A,    1'b0, 1'b1, X_ZERO, 1'b0, Z_ZERO, 1'b0, F_ADD)
  };
endpackage

// File: rtl/mid_reg.sv
module mid_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (ce_i)  q_o <= d_i;
  end
endmodule

// File: rtl/mul_stage.sv
module mul_stage import mac_instr_pkg::*; #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int D_W = 18
) (
  input  mac_instr_pkg::pre_e    pre_i,
  input  logic                   b_one_i,
  input  logic signed [A_W-1:0]  a_i,
  input  logic signed [B_W-1:0]  b_i,
  input  logic signed [D_W-1:0]  d_i,
  output logic signed [P_W-1:0]  m_o
);
  localparam int PRE_W  = ((A_W > D_W) ? A_W : D_W) + 1;
  localparam int PROD_W = PRE_W + B_W;

  logic signed [PRE_W-1:0]  ae, de, pre;
  logic signed [PROD_W-1:0] prod;

  assign ae = PRE_W'(a_i);
  assign de = PRE_W'(d_i);

  always_comb begin
    unique case (pre_i)
      PRE_ADD:  pre = ae + de;
      PRE_DSUB: pre = de - ae;
      PRE_D:    pre = de;
      PRE_NEGA: pre = -ae;
      default:  pre = ae;
    endcase
  end

  // unit factor passes the pre-adder straight through
  assign prod = b_one_i ? PROD_W'(pre) : pre * b_i;
  assign m_o  = P_W'(prod);
endmodule

// File: rtl/alu_stage.sv
module alu_stage import mac_instr_pkg::*; (
  input  mac_instr_pkg::instr_t ins_i,
  input  logic signed [P_W-1:0] m_i,
  input  logic signed [P_W-1:0] cat_i,
  input  logic signed [P_W-1:0] c_i,
  input  logic signed [P_W-1:0] p_i,
  input  logic                  cin_i,
  output logic signed [P_W-1:0] p_o
);
  logic signed [P_W-1:0] x, y, z, xy, ci;

  always_comb begin
    unique case (ins_i.x)
      X_CAT:   x = cat_i;
      X_P:     x = p_i;
      default: x = '0;
    endcase
    y = ins_i.y_c ? c_i : '0;
    unique case (ins_i.z)
      Z_C:     z = c_i;
      Z_P:     z = p_i;
      Z_PSH:   z = p_i >>> SHIFT_AMT;
      default: z = '0;
    endcase
    xy = ins_i.use_mult ? m_i : x + y;
    ci = P_W'({1'b0, ins_i.cin_en & cin_i});
    unique case (ins_i.form)
      F_ZSUB:  p_o = z - (xy + ci);
      F_NEGZ:  p_o = xy - z;
      default: p_o = xy + z + ci;
    endcase
  end
endmodule

// File: rtl/mac_instr_dp.sv
module mac_instr_dp import mac_instr_pkg::*; #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int D_W = 18,
  parameter int N_INSTR = 7,
  parameter mac_instr_pkg::instr_t [N_INSTR-1:0] TABLE = mac_instr_pkg::DEF_TABLE,
  localparam int SEL_W = (N_INSTR > 1) ? $clog2(N_INSTR) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NPATH-1:0]            ce_i,
  input  logic [NPATH-1:0]            clr_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic signed [A_W-1:0]       a_i,
  input  logic signed [B_W-1:0]       b_i,
  input  logic signed [D_W-1:0]       d_i,
  input  logic signed [P_W-1:0]       c_i,
  input  logic                        cin_i,
  output logic signed [P_W-1:0]       p_o
);
  localparam int SEL_STAGES = 2;
  localparam int CAT_W = A_W + B_W;

  function automatic bit table_ok();
    bit any_mult = 1'b0, any_cat = 1'b0;
    for (int i = 0; i < N_INSTR; i++) begin
      any_mult |= TABLE[i].use_mult;
      any_cat  |= (TABLE[i].x == X_CAT);
    end
    return !(any_mult && any_cat);
  endfunction

  if (!table_ok()) begin : g_bad_table
    $error("instruction table mixes multiplier and concatenated operand");
  end
  if (CAT_W > P_W) begin : g_bad_width
    $error("concatenated operand wider than result");
  end

  function automatic instr_t decode(logic [SEL_W-1:0] s);
    if ({1'b0, s} < (SEL_W+1)'(N_INSTR)) return TABLE[s];
    return '0;
  endfunction

  // stage 1
  logic signed [A_W-1:0] a_q;
  logic signed [B_W-1:0] b_q;
  logic signed [D_W-1:0] d_q;
  logic signed [P_W-1:0] c_q1, c_q2;

  mid_reg #(A_W) u_a (.clk_i, .rst_ni, .ce_i(ce_i[PATH_A]), .clr_i(clr_i[PATH_A]), .d_i(a_i), .q_o(a_q));
  mid_reg #(B_W) u_b (.clk_i, .rst_ni, .ce_i(ce_i[PATH_B]), .clr_i(clr_i[PATH_B]), .d_i(b_i), .q_o(b_q));
  mid_reg #(D_W) u_d (.clk_i, .rst_ni, .ce_i(ce_i[PATH_D]), .clr_i(clr_i[PATH_D]), .d_i(d_i), .q_o(d_q));
  mid_reg #(P_W) u_c1 (.clk_i, .rst_ni, .ce_i(ce_i[PATH_C]), .clr_i(clr_i[PATH_C]), .d_i(c_i), .q_o(c_q1));
  mid_reg #(P_W) u_c2 (.clk_i, .rst_ni, .ce_i(ce_i[PATH_C]), .clr_i(clr_i[PATH_C]), .d_i(c_q1), .q_o(c_q2));

  // select and carry travel together, one stage per data stage
  logic [SEL_W:0] sc_pipe [SEL_STAGES+1];
  assign sc_pipe[0] = {cin_i, sel_i};
  for (genvar s = 0; s < SEL_STAGES; s++) begin : g_sel
    mid_reg #(SEL_W+1) u_r (.clk_i, .rst_ni, .ce_i(ce_i[PATH_SEL]), .clr_i(clr_i[PATH_SEL]),
                            .d_i(sc_pipe[s]), .q_o(sc_pipe[s+1]));
  end

  instr_t ins1, ins2;
  assign ins1 = decode(sc_pipe[1][SEL_W-1:0]);
  assign ins2 = decode(sc_pipe[2][SEL_W-1:0]);

  // stage 2
  logic signed [P_W-1:0]   m_d, m_q, cat_d, cat_q;
  logic signed [CAT_W-1:0] cat_raw;

  mul_stage #(.A_W(A_W), .B_W(B_W), .D_W(D_W)) u_mul (
    .pre_i(ins1.pre), .b_one_i(ins1.b_one), .a_i(a_q), .b_i(b_q), .d_i(d_q), .m_o(m_d));

  assign cat_raw = {a_q, b_q};
  assign cat_d   = P_W'(cat_raw);

  mid_reg #(P_W) u_m   (.clk_i, .rst_ni, .ce_i(ce_i[PATH_M]), .clr_i(clr_i[PATH_M]), .d_i(m_d), .q_o(m_q));
  mid_reg #(P_W) u_cat (.clk_i, .rst_ni, .ce_i(ce_i[PATH_M]), .clr_i(clr_i[PATH_M]), .d_i(cat_d), .q_o(cat_q));

  // stage 3
  logic signed [P_W-1:0] p_d, p_q;

  alu_stage u_alu (.ins_i(ins2), .m_i(m_q), .cat_i(cat_q), .c_i(c_q2), .p_i(p_q),
                   .cin_i(sc_pipe[2][SEL_W]), .p_o(p_d));

  mid_reg #(P_W) u_p (.clk_i, .rst_ni, .ce_i(ce_i[PATH_P]), .clr_i(clr_i[PATH_P]), .d_i(p_d), .q_o(p_q));

  assign p_o = p_q;
endmodule

// File: rtl/mac_instr_dp_chk.sv
module mac_instr_dp_chk import mac_instr_pkg::*; #(
  parameter int N_INSTR = 7,
  parameter int SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPATH-1:0] ce_i,
  input logic [NPATH-1:0] clr_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [P_W-1:0]   p_o
);
  logic [1:0] since_rst;
  logic       oor, all_ce;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign oor    = {1'b0, sel_i} >= (SEL_W+1)'(N_INSTR);
  assign all_ce = &ce_i;

  p_reset_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> p_o == '0);

  p_oor_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3 && $past(oor, 3) && $past(all_ce, 3) && $past(all_ce, 2) && $past(all_ce, 1))
    |-> p_o == '0);

  p_clr_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i[PATH_P] |=> p_o == '0);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i[PATH_P] && !clr_i[PATH_P]) |=> $stable(p_o));
endmodule

bind mac_instr_dp mac_instr_dp_chk #(.N_INSTR(N_INSTR), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .clr_i(clr_i), .sel_i(sel_i), .p_o(p_o));

// File: tb/sim_mac_instr_dp.sv
module sim_mac_instr_dp;
  import mac_instr_pkg::*;

  localparam instr_t [3:0] CAT_TAB = {
    mk(PRE_A, 1'b0, 1'b0, X_CAT,  1'b0, Z_C,    1'b0, F_NEGZ),  // 3: cat - C
    mk(PRE_A, 1'b0, 1'b0, X_CAT,  1'b0, Z_P,    1'b1, F_ZSUB),  // 2: P - (cat+cin)
    mk(PRE_A, 1'b0, 1'b0, X_P,    1'b1, Z_ZERO, 1'b0, F_ADD),   // 1: P + C
    mk(PRE_A, 1'b0, 1'b0, X_CAT,  1'b1, Z_ZERO, 1'b1, F_ADD)    // 0: cat + C + cin
  };
  localparam int NOPS = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NPATH-1:0] ce = '1, clr = '0;
  logic [2:0] sel0 = '0;
  logic [1:0] sel1 = '0;
  logic signed [17:0] a = '0, b = '0, d = '0;
  logic signed [47:0] c = '0;
  logic cin = 1'b0;
  logic signed [47:0] p0, p1;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mac_instr_dp u0 (.clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .clr_i(clr), .sel_i(sel0),
                   .a_i(a), .b_i(b), .d_i(d), .c_i(c), .cin_i(cin), .p_o(p0));
  mac_instr_dp #(.N_INSTR(4), .TABLE(CAT_TAB)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .clr_i(clr), .sel_i(sel1),
    .a_i(a), .b_i(b), .d_i(d), .c_i(c), .cin_i(cin), .p_o(p1));

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [47:0] model0(int s, longint av, longint bv, longint dv,
                                         longint cv, longint ci, longint pv);
    longint r;
    case (s)
      0: r = av * bv;
      1: r = (av + dv) * bv + pv;
      2: r = (dv - av) * bv + cv + ci;
      3: r = cv - (av * bv + ci);
      4: r = dv * bv - pv;
      5: r = -av + (pv >>> 17);
      6: r = av + dv;
      default: r = 0;
    endcase
    return r[47:0];
  endfunction

  function automatic logic [47:0] model1(int s, longint cc, longint cv, longint ci, longint pv);
    longint r;
    case (s)
      0: r = cc + cv + ci;
      1: r = pv + cv;
      2: r = pv - (cc + ci);
      default: r = cc - cv;
    endcase
    return r[47:0];
  endfunction

  function automatic logic signed [17:0] corner(int k);
    case (k)
      0: return -18'sd131072;
      1: return -18'sd1;
      2: return 18'sd0;
      3: return 18'sd1;
      default: return 18'sd131071;
    endcase
  endfunction

  function automatic string tag0(int s);
    case (s)
      0, 2: return "R3";
      1, 5: return "R5";
      3, 4: return "R6";
      6: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic drive_mul(input int s, input logic signed [17:0] av, input logic signed [17:0] bv);
    sel0 = 3'(s); a = av; b = bv; d = '0; c = '0; cin = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] ring0 [4];
    logic [47:0] ring1 [4];
    string rtag [4];
    logic signed [47:0] prev0, prev1;
    logic signed [35:0] cat;
    prev0 = '0; prev1 = '0;

    repeat (3) @(negedge clk);
    check("R1", p0, '0);
    check("R1", p1, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", p0, '0);

    // sweep: every select x every corner combination; R2 timing on every check
    for (int i = 0; i < NOPS + 3; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check(rtag[(i-3)%4], p0, ring0[(i-3)%4]);
        check("R7", p1, ring1[(i-3)%4]);
      end
      if (i < NOPS) begin
        int idx;
        idx = i / 8;
        sel0 = 3'(i % 8);
        sel1 = 2'(i % 4);
        a = corner(idx % 5);
        b = corner((idx / 5) % 5);
        d = corner(idx / 25);
        c = {$urandom, $urandom} >> 16;
        if (i % 3 == 0) c = -c;
        cin = 1'($urandom);
      end else begin
        sel0 = '0; sel1 = 2'd0; a = '0; b = '0; d = '0; c = '0; cin = 1'b0;
      end
      cat = {a, b};
      ring0[i%4] = model0(int'(sel0), longint'(a), longint'(b), longint'(d),
                          longint'(c), longint'(cin), longint'(prev0));
      ring1[i%4] = model1(int'(sel1), longint'(cat), longint'(c), longint'(cin), longint'(prev1));
      rtag[i%4] = tag0(int'(sel0));
      prev0 = ring0[i%4];
      prev1 = ring1[i%4];
    end

    // R2: exact latency edge
    @(negedge clk); drive_mul(0, 18'sd3, 18'sd4);
    @(negedge clk); drive_mul(0, 18'sd0, 18'sd0);
    @(negedge clk); check("R2", p0, '0);
    @(negedge clk); check("R2", p0, 48'd12);
    @(negedge clk); check("R2", p0, '0);

    // R10: A path frozen for one issue, B path fresh
    drive_mul(0, 18'sd3, 18'sd4);
    @(negedge clk); a = 18'sd100; b = 18'sd5; ce[PATH_A] = 1'b0;
    @(negedge clk); ce = '1; drive_mul(0, 18'sd0, 18'sd0);
    @(negedge clk); check("R10", p0, 48'd12);
    @(negedge clk); check("R10", p0, 48'd15);
    @(negedge clk); check("R10", p0, '0);

    // R11 hold, then R9 clear while enable low
    drive_mul(0, -18'sd3, 18'sd4);
    @(negedge clk); drive_mul(0, 18'sd0, 18'sd0);
    @(negedge clk);
    @(negedge clk); check("R11", p0, -48'sd12);
    drive_mul(1, 18'sd7, 18'sd7); ce[PATH_P] = 1'b0;
    @(negedge clk); check("R11", p0, -48'sd12);
    @(negedge clk); check("R11", p0, -48'sd12);
    @(negedge clk); check("R11", p0, -48'sd12);
    clr[PATH_P] = 1'b1;
    @(negedge clk); check("R9", p0, '0);
    clr = '0; ce = '1; drive_mul(0, 18'sd0, 18'sd0);

    // R9: clearing the A path zeroes the operand that would have been loaded
    repeat (3) @(negedge clk);
    drive_mul(0, 18'sd6, 18'sd2); clr[PATH_A] = 1'b1;
    @(negedge clk); clr = '0; drive_mul(0, 18'sd0, 18'sd0);
    @(negedge clk);
    @(negedge clk); check("R9", p0, '0);

    // R8: out-of-range select after nonzero state
    drive_mul(0, 18'sd5, 18'sd5);
    @(negedge clk); drive_mul(7, 18'sd9, 18'sd9);
    @(negedge clk); drive_mul(0, 18'sd0, 18'sd0);
    @(negedge clk); check("R8", p0, 48'd25);
    @(negedge clk); check("R8", p0, '0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule